// File: doc/BRIEF.md
# Shared Display Memory Access Controller

This block holds the three memories behind a raster or vector display path. Two are byte-wide and hold vertical and horizontal deflection samples. The third is one bit wide and marks which points are drawn brightened. A waveform processor reaches all three through fixed windows in its address space, and it uses a read line and a write strobe to do so. For readout, a display address source takes over the shared address path. It then reads the same location from all three memories at once.

The block decodes the processor address into a memory select and gates the write strobe. It returns read data one cycle after the address is presented, and it tells the processor bus when it is driving. The one-bit memory appears on the top data bit of the byte bus. It has twice as many entries as its processor window, so a bank bit in a write-only control register picks which half the processor sees. The same bank bit also supplies the top address bit during display readout.

Top module: `disp_mem_hub`

## Requirements
- R1: A processor write with `cpu_rd_n` high and `cpu_wr` high to addresses 0x2000..0x27FF stores `cpu_wdata` in the vertical memory at the address offset. A later read of the same address returns that byte.
- R2: Addresses 0x2800..0x2FFF reach the horizontal memory in the same way. Its contents are separate from the vertical memory.
- R3: A write to 0x3000..0x37FF stores data bit 7 in the intensify memory. A read there returns the stored bit on bit 7, with bits 6..0 at zero.
- R4: A processor write to 0x3800 loads data bit 0 into the bank bit, which resets to 0. The bank bit selects the lower (0) or upper (1) 2K half of the intensify memory for processor accesses and for display readout.
- R5: When `cpu_rd_n` is low on a clock edge with an address inside 0x2000..0x37FF, `cpu_drive` is high for the next cycle and `cpu_rdata` carries the addressed data.
- R6: An access outside 0x2000..0x37FF changes no memory, leaves `cpu_drive` low, and returns 0 on `cpu_rdata`. While `cpu_drive` is low, `cpu_rdata` is 0.
- R7: While `disp_own` is high, processor writes change no memory and processor reads leave `cpu_drive` low.
- R8: While `disp_own` is high, `disp_vert`, `disp_horz` and `disp_bright` show, one cycle later, the contents of all three memories at `disp_addr`. `disp_bright` is taken from the half chosen by the bank bit. While `disp_own` is low, these outputs hold their values.
- R9: After reset, `cpu_drive`, `cpu_rdata`, `disp_vert`, `disp_horz` and `disp_bright` are all 0.
- R10: When `cpu_rd_n` is low, the access is a read even if `cpu_wr` is high, and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd_n | input | 1 | Active-low read request |
| cpu_wr | input | 1 | Write strobe, sampled on the clock edge |
| cpu_rdata | output | 8 | Read data, zero when not driving |
| cpu_drive | output | 1 | High when the block drives the processor bus |
| disp_own | input | 1 | High when the display source owns the address path |
| disp_addr | input | 11 | Display scan address |
| disp_vert | output | 8 | Vertical sample read out for display |
| disp_horz | output | 8 | Horizontal sample read out for display |
| disp_bright | output | 1 | Intensify bit read out for display |

## Verification
The bench builds the block with its default parameters: 16-bit processor address, 8-bit data, 2K windows and a base of 0x2000. This places the window edges at 0x2000, 0x2800, 0x3000 and 0x3800, which are the exact addresses the requirements name. The bench probes the first and last address of each window and the addresses just outside them. It also checks that out-of-range writes, whose low address bits alias real locations, leave stored data intact. Both bank settings are exercised from the processor side and during display readout.

// File: rtl/disp_mem_hub.sv
module disp_mem_hub #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SEG_W     = 11,
  parameter int VERT_BASE = 'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_drive,
  input  logic              disp_own,
  input  logic [SEG_W-1:0]  disp_addr,
  output logic [DATA_W-1:0] disp_vert,
  output logic [DATA_W-1:0] disp_horz,
  output logic              disp_bright
);
  localparam int DEPTH = 1 << SEG_W;
  localparam int SHI_W = ADDR_W - SEG_W;
  localparam logic [SHI_W-1:0] V_SEG = SHI_W'(VERT_BASE >> SEG_W);
  localparam logic [SHI_W-1:0] H_SEG = V_SEG + SHI_W'(1);
  localparam logic [SHI_W-1:0] A_SEG = V_SEG + SHI_W'(2);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(VERT_BASE + 3 * DEPTH);

  logic [DATA_W-1:0] vmem [DEPTH];
  logic [DATA_W-1:0] hmem [DEPTH];
  logic              amem [2*DEPTH];
  logic              bank;

  wire [SHI_W-1:0] seg   = cpu_addr[ADDR_W-1:SEG_W];
  wire             cpu_on = !disp_own;
  wire             sel_v = cpu_on && (seg == V_SEG);
  wire             sel_h = cpu_on && (seg == H_SEG);
  wire             sel_a = cpu_on && (seg == A_SEG);
  wire             rd    = !cpu_rd_n;
  wire             wr_ok = cpu_wr && cpu_rd_n && cpu_on;

  wire [SEG_W-1:0] mem_addr = disp_own ? disp_addr : cpu_addr[SEG_W-1:0];
  wire [SEG_W:0]   a_idx    = {bank, mem_addr};

  always_ff @(posedge clk) begin
    if (wr_ok && sel_v) vmem[mem_addr] <= cpu_wdata;
    if (wr_ok && sel_h) hmem[mem_addr] <= cpu_wdata;
    if (wr_ok && sel_a) amem[a_idx]    <= cpu_wdata[DATA_W-1];
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rd) begin
      if (sel_v)      rd_mux = vmem[mem_addr];
      else if (sel_h) rd_mux = hmem[mem_addr];
      else if (sel_a) rd_mux = {amem[a_idx], {(DATA_W-1){1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank        <= 1'b0;
      cpu_drive   <= 1'b0;
      cpu_rdata   <= '0;
      disp_vert   <= '0;
      disp_horz   <= '0;
      disp_bright <= 1'b0;
    end else begin
      if (wr_ok && cpu_addr == CTRL_ADDR) bank <= cpu_wdata[0];
      cpu_drive <= rd && (sel_v || sel_h || sel_a);
      cpu_rdata <= rd_mux;
      if (disp_own) begin
        disp_vert   <= vmem[mem_addr];
        disp_horz   <= hmem[mem_addr];
        disp_bright <= amem[a_idx];
      end
    end
  end
endmodule

// File: rtl/disp_mem_hub_chk.sv
module disp_mem_hub_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SEG_W     = 11,
  parameter int VERT_BASE = 'h2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_rd_n,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              cpu_drive,
  input logic              disp_own,
  input logic [SEG_W-1:0]  disp_addr,
  input logic [DATA_W-1:0] disp_vert,
  input logic [DATA_W-1:0] disp_horz,
  input logic              disp_bright
);
  localparam int LO = VERT_BASE;
  localparam int HI = VERT_BASE + 3 * (1 << SEG_W);
  localparam int AT = VERT_BASE + 2 * (1 << SEG_W);

  wire in_win  = (int'(cpu_addr) >= LO) && (int'(cpu_addr) < HI);
  wire in_attr = (int'(cpu_addr) >= AT) && (int'(cpu_addr) < HI);

  assert_drive_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_drive |-> $past(!cpu_rd_n && in_win && !disp_own));

  assert_read_gets_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd_n && in_win && !disp_own) |=> cpu_drive);

  assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_drive |-> (cpu_rdata == '0));

  assert_attr_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd_n && in_attr && !disp_own) |=> (cpu_rdata[DATA_W-2:0] == '0));

  assert_no_read_in_display_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_own |=> !cpu_drive);

  assert_display_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_own |=> ($stable(disp_vert) && $stable(disp_horz) && $stable(disp_bright)));
endmodule

bind disp_mem_hub disp_mem_hub_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W), .VERT_BASE(VERT_BASE)
) u_chk (.*);

// File: tb/disp_mem_hub_bench.sv
module disp_mem_hub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd_n = 1'b1;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        cpu_drive;
  logic        disp_own = 1'b0;
  logic [10:0] disp_addr = '0;
  logic [7:0]  disp_vert, disp_horz;
  logic        disp_bright;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  disp_mem_hub u_disp_mem_hub (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd_n = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [15:0] a, output logic [7:0] d, output logic drv);
    @(negedge clk);
    cpu_addr = a; cpu_rd_n = 1'b0;
    @(negedge clk);
    d = cpu_rdata; drv = cpu_drive;
    cpu_rd_n = 1'b1;
  endtask

  task automatic expect_read(input string req, input logic [15:0] a, input logic [7:0] exp, input logic exp_drv);
    logic [7:0] d; logic drv;
    cpu_read(a, d, drv);
    chk(req, int'(drv), int'(exp_drv));
    chk(req, int'(d), int'(exp));
  endtask

  task automatic disp_look(input logic [10:0] a, output logic [7:0] v, output logic [7:0] h, output logic b);
    @(negedge clk);
    disp_addr = a;
    @(negedge clk);
    v = disp_vert; h = disp_horz; b = disp_bright;
  endtask

  task automatic t_reset;
    chk("R9 drive", int'(cpu_drive), 0);
    chk("R9 rdata", int'(cpu_rdata), 0);
    chk("R9 vert", int'(disp_vert), 0);
    chk("R9 horz", int'(disp_horz), 0);
    chk("R9 bright", int'(disp_bright), 0);
  endtask

  task automatic t_vert;
    cpu_write(16'h2000, 8'h11);
    cpu_write(16'h27FF, 8'hA5);
    expect_read("R1 first", 16'h2000, 8'h11, 1'b1);
    expect_read("R1 last", 16'h27FF, 8'hA5, 1'b1);
  endtask

  task automatic t_horz;
    cpu_write(16'h2800, 8'h3C);
    cpu_write(16'h2FFF, 8'h81);
    expect_read("R2 first", 16'h2800, 8'h3C, 1'b1);
    expect_read("R2 last", 16'h2FFF, 8'h81, 1'b1);
    expect_read("R2 vert intact", 16'h2000, 8'h11, 1'b1);
  endtask

  task automatic t_attr;
    cpu_write(16'h3000, 8'h80);
    cpu_write(16'h3001, 8'h7F);
    cpu_write(16'h37FF, 8'hC3);
    expect_read("R3 set", 16'h3000, 8'h80, 1'b1);
    expect_read("R3 clear", 16'h3001, 8'h00, 1'b1);
    expect_read("R3 last", 16'h37FF, 8'h80, 1'b1);
  endtask

  task automatic t_bank;
    cpu_write(16'h3800, 8'h01);
    cpu_write(16'h3000, 8'h00);
    expect_read("R4 upper", 16'h3000, 8'h00, 1'b1);
    cpu_write(16'h3800, 8'h00);
    expect_read("R4 lower", 16'h3000, 8'h80, 1'b1);
  endtask

  task automatic t_outside;
    expect_read("R6 below", 16'h1FFF, 8'h00, 1'b0);
    expect_read("R6 ctrl", 16'h3800, 8'h00, 1'b0);
    expect_read("R6 above", 16'h4000, 8'h00, 1'b0);
    cpu_write(16'h1800, 8'hFF);
    cpu_write(16'h4000, 8'hFF);
    cpu_write(16'h4800, 8'h00);
    expect_read("R6 vert kept", 16'h2000, 8'h11, 1'b1);
    expect_read("R6 horz kept", 16'h2800, 8'h3C, 1'b1);
    expect_read("R6 attr kept", 16'h3000, 8'h80, 1'b1);
  endtask

  task automatic t_rdprio;
    logic [7:0] d; logic drv;
    @(negedge clk);
    cpu_addr = 16'h27FF; cpu_wdata = 8'h00; cpu_wr = 1'b1; cpu_rd_n = 1'b0;
    @(negedge clk);
    d = cpu_rdata; drv = cpu_drive;
    cpu_wr = 1'b0; cpu_rd_n = 1'b1;
    chk("R10 read data", int'(d), 8'hA5);
    chk("R10 drive", int'(drv), 1);
    expect_read("R10 not written", 16'h27FF, 8'hA5, 1'b1);
  endtask

  task automatic t_display;
    logic [7:0] v, h; logic b;
    @(negedge clk);
    disp_own = 1'b1;
    disp_look(11'h000, v, h, b);
    chk("R8 vert 0", int'(v), 8'h11);
    chk("R8 horz 0", int'(h), 8'h3C);
    chk("R8 bright 0", int'(b), 1);
    disp_look(11'h7FF, v, h, b);
    chk("R8 vert 7FF", int'(v), 8'hA5);
    chk("R8 horz 7FF", int'(h), 8'h81);
    chk("R8 bright 7FF", int'(b), 1);
    disp_look(11'h001, v, h, b);
    chk("R8 bright 1", int'(b), 0);
    @(negedge clk);
    disp_own = 1'b0;
    cpu_write(16'h3800, 8'h01);
    @(negedge clk);
    disp_own = 1'b1;
    disp_look(11'h000, v, h, b);
    chk("R4 display upper", int'(b), 0);
    @(negedge clk);
    disp_own = 1'b0;
    cpu_write(16'h3800, 8'h00);
    cpu_write(16'h2000, 8'h5A);
    chk("R8 hold vert", int'(disp_vert), 8'h11);
    chk("R8 hold bright", int'(disp_bright), 0);
    cpu_write(16'h2000, 8'h11);
  endtask

  task automatic t_block;
    logic [7:0] d; logic drv;
    @(negedge clk);
    disp_own = 1'b1;
    cpu_write(16'h2000, 8'hEE);
    cpu_write(16'h2800, 8'hEE);
    cpu_write(16'h3000, 8'h00);
    cpu_read(16'h2000, d, drv);
    chk("R7 no drive", int'(drv), 0);
    chk("R7 no data", int'(d), 0);
    @(negedge clk);
    disp_own = 1'b0;
    expect_read("R7 vert kept", 16'h2000, 8'h11, 1'b1);
    expect_read("R7 horz kept", 16'h2800, 8'h3C, 1'b1);
    expect_read("R7 attr kept", 16'h3000, 8'h80, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_vert();
    t_horz();
    t_attr();
    t_bank();
    t_outside();
    t_rdprio();
    t_display();
    t_block();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule